// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block generates the chip's internal active-low reset and a tri-statable reset output for the board. It watches three digital indications: supply good, oscillator running, and an active-low external reset pin. While any of them is low, the reset output pad is actively driven low and the internal reset is held.

Once all three are high, the block waits for a short synchroniser settle time. It then lets the pad float for a programmable number of oscillator cycles; the default of 30,000 cycles gives 5 ms at 6 MHz. After that wait, the pad is driven high and the internal reset is released in the same cycle. A pull-up on a USB data line can be wired to the pad, so the delay also postpones enumeration.

Any release condition that drops, at any time, puts the block straight back into the driven-low state without waiting for a clock edge. The wait then starts again from zero.

Top module: `por_sequencer`

## Requirements
- R1: While any of `supply_ok`, `osc_ok` or `ext_rst_n` is low, the outputs are `pad_oe`=1, `pad_out`=0 and `int_rst_n`=0, and they take these values without waiting for a clock edge.
- R2: After all three inputs are high, the pad stays driven low through the first `SYNC_STAGES` rising edges. It goes high-impedance (`pad_oe`=0, `int_rst_n`=0) at edge number `SYNC_STAGES`.
- R3: The high-impedance phase lasts exactly `DELAY_CYCLES` clock cycles.
- R4: At the edge that ends the high-impedance phase, `pad_oe`=1, `pad_out`=1 and `int_rst_n`=1 all take effect together.
- R5: While all three inputs stay high, the released state (`pad_oe`=1, `pad_out`=1, `int_rst_n`=1) persists.
- R6: A condition that drops during the high-impedance phase returns the block to the driven-low state. The next release waits the full `SYNC_STAGES` + `DELAY_CYCLES` again.
- R7: A condition that drops after release returns the block to the driven-low state. The next release repeats the full sequence.
- R8: A low pulse on `ext_rst_n` that starts and ends between two clock edges still resets the block.
- R9: Holding any single one of the three inputs low, with the other two high, blocks release for as long as it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock that counts the delay |
| supply_ok | input | 1 | Supply-above-threshold indication, high when good |
| osc_ok | input | 1 | Oscillator-running indication, high when stable |
| ext_rst_n | input | 1 | External reset request, active low |
| pad_oe | output | 1 | Output enable for the reset pad, 1 = drive |
| pad_out | output | 1 | Value driven onto the reset pad when enabled |
| int_rst_n | output | 1 | Internal reset for the rest of the chip, active low |

## Verification
A clean release from power-up is counted edge by edge, so it separates the settle time from the floating phase and the final release. Each input is then held low on its own while the other two are high, which shows that every one of the three gates release. Drops during the floating phase and after release show that the wait restarts from zero rather than resuming from where it stopped. A reset pulse shorter than one clock period, lying wholly between two edges, shows that reset assertion does not depend on the clock.

// File: rtl/por_pkg.sv
// Shared definitions for the power-on reset sequencer.
// Assumes nothing beyond a single oscillator clock domain.
package por_pkg;

    // Pad phase that the sequencer is in.
    typedef enum logic [1:0] {
        PH_DRIVE_LOW  = 2'd0,
        PH_FLOAT      = 2'd1,
        PH_DRIVE_HIGH = 2'd2
    } pad_phase_t;

endpackage

// File: rtl/por_release_sync.sv
// Release synchroniser: clears at once when the combined condition falls,
// and lets its output rise only after STAGES rising clock edges.
// Assumes cond_ok may change at any time relative to clk.
module por_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic cond_ok,
    output logic armed
);

    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;

            // Single flop: clear asynchronously, set on the next edge.
            always_ff @(posedge clk or negedge cond_ok) begin
                if (!cond_ok) begin
                    stage_q <= 1'b0;
                end else begin
                    stage_q <= 1'b1;
                end
            end

            assign armed = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;

            // Shift chain: clear asynchronously, fill with ones one per edge.
            always_ff @(posedge clk or negedge cond_ok) begin
                if (!cond_ok) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], 1'b1};
                end
            end

            assign armed = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/por_delay_timer.sv
// Delay timer: counts DELAY_CYCLES edges while armed, then raises done.
// done stays high until armed drops, which clears it at once.
// Assumes DELAY_CYCLES >= 1.
module por_delay_timer #(
    parameter int DELAY_CYCLES = 30000
) (
    input  logic clk,
    input  logic armed,
    output logic done
);

    localparam int CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Count armed cycles and latch done on the final one.
    always_ff @(posedge clk or negedge armed) begin
        if (!armed) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!armed)
        cnt_q <= LAST);  // R3
    AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!armed)
        $rose(done_q) |-> ($past(cnt_q) == LAST));  // R3
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!armed)
        done_q |=> done_q);  // R5

endmodule

// File: rtl/por_pad_ctl.sv
// Pad control: maps the sync and timer state onto the pad phase and the
// internal reset. Purely combinational, so a drop reaches the pad at once.
// Assumes done can only be high while armed is high.
module por_pad_ctl
    import por_pkg::*;
(
    input  logic clk,
    input  logic armed,
    input  logic done,
    output logic pad_oe,
    output logic pad_out,
    output logic int_rst_n
);

    pad_phase_t phase;

    // Select the pad phase from the release progress.
    always_comb begin
        if (!armed) begin
            phase = PH_DRIVE_LOW;
        end else if (!done) begin
            phase = PH_FLOAT;
        end else begin
            phase = PH_DRIVE_HIGH;
        end
    end

    // Decode the phase into pad enable, pad value and internal reset.
    always_comb begin
        pad_oe    = 1'b1;
        pad_out   = 1'b0;
        int_rst_n = 1'b0;
        case (phase)
            PH_FLOAT: begin
                pad_oe = 1'b0;
            end
            PH_DRIVE_HIGH: begin
                pad_out   = 1'b1;
                int_rst_n = 1'b1;
            end
            default: begin
                pad_oe = 1'b1;
            end
        endcase
    end

    AST_FLOAT_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!armed)
        $rose(int_rst_n) |-> $past(!pad_oe));  // R4

endmodule

// File: rtl/por_sequencer.sv
// Power-on reset sequencer top. Combines supply, oscillator and external
// reset into one release condition, synchronises its release, times the
// floating phase and drives the pad and the internal reset.
// Assumes clk is the oscillator clock and all inputs are already digital.
module por_sequencer #(
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_CYCLES = 30000
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic osc_ok,
    input  logic ext_rst_n,
    output logic pad_oe,
    output logic pad_out,
    output logic int_rst_n
);

    logic cond_ok;
    logic armed;
    logic done;

    assign cond_ok = supply_ok & osc_ok & ext_rst_n;

    por_release_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .cond_ok (cond_ok),
        .armed   (armed)
    );

    por_delay_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .armed (armed),
        .done  (done)
    );

    por_pad_ctl u_pad (
        .clk       (clk),
        .armed     (armed),
        .done      (done),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .int_rst_n (int_rst_n)
    );

    AST_LOW_WHILE_HELD: assert property (@(posedge clk)
        !cond_ok |-> (pad_oe && !pad_out && !int_rst_n));  // R1
    AST_RELEASE_NEEDS_ALL: assert property (@(posedge clk)
        int_rst_n |-> (supply_ok && osc_ok && ext_rst_n));  // R9
    AST_RELEASE_DRIVES_HIGH: assert property (@(posedge clk)
        int_rst_n |-> (pad_oe && pad_out));  // R4

endmodule

// File: tb/tb_por_sequencer.sv
// Directed bench for the power-on reset sequencer.
module tb_por_sequencer;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SYNC = 2;
    localparam int DLY  = 20;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic osc_ok = 1'b0;
    logic ext_rst_n = 1'b0;
    logic pad_oe, pad_out, int_rst_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    por_sequencer #(
        .SYNC_STAGES  (SYNC),
        .DELAY_CYCLES (DLY)
    ) dut (
        .clk       (clk),
        .supply_ok (supply_ok),
        .osc_ok    (osc_ok),
        .ext_rst_n (ext_rst_n),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .int_rst_n (int_rst_n)
    );

    task automatic expect_out(input string req, input logic e_oe, input logic e_out,
                              input logic e_rn);
        checks++;
        if (pad_oe !== e_oe || (e_oe && pad_out !== e_out) || int_rst_n !== e_rn) begin
            errors++;
            $display("FAIL %s: oe/out/rst_n actual %b%b%b expected %b%b%b at %0t",
                     req, pad_oe, pad_out, int_rst_n, e_oe, e_out, e_rn, $time);
        end
    endtask

    task automatic set_in(input logic s, input logic o, input logic e);
        @(negedge clk);
        supply_ok = s;
        osc_ok    = o;
        ext_rst_n = e;
    endtask

    // Inputs have just gone all-high between edges; walk the full sequence.
    task automatic walk_release(input string req);
        for (int i = 1; i < SYNC; i++) begin
            @(posedge clk); #1;
            expect_out({req, "/R2 settle"}, 1'b1, 1'b0, 1'b0);
        end
        @(posedge clk); #1;
        expect_out({req, "/R2 float"}, 1'b0, 1'b0, 1'b0);
        repeat (DLY - 1) @(posedge clk);
        #1;
        expect_out({req, "/R3 still float"}, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        expect_out({req, "/R4 released"}, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_reset_state();
        repeat (5) @(posedge clk);
        #1;
        expect_out("R1 reset", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_first_release();
        set_in(1'b1, 1'b1, 1'b1);
        walk_release("R2");
    endtask

    task automatic t_hold();
        repeat (50) @(posedge clk);
        #1;
        expect_out("R5 hold", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_single_low(input int which);
        set_in(which != 0, which != 1, which != 2);
        #1;
        expect_out("R1 drop", 1'b1, 1'b0, 1'b0);
        repeat (2 * DLY + 5) @(posedge clk);
        #1;
        expect_out("R9 blocked", 1'b1, 1'b0, 1'b0);
        set_in(1'b1, 1'b1, 1'b1);
        walk_release("R9");
    endtask

    task automatic t_drop_in_float();
        set_in(1'b0, 1'b1, 1'b1);
        set_in(1'b1, 1'b1, 1'b1);
        repeat (SYNC + 5) @(posedge clk);
        #1;
        expect_out("R6 mid float", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        osc_ok = 1'b0;
        #0.5;
        expect_out("R6 drop", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        osc_ok = 1'b1;
        walk_release("R6");
    endtask

    task automatic t_drop_after_release();
        @(negedge clk);
        supply_ok = 1'b0;
        #0.5;
        expect_out("R7 drop", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        supply_ok = 1'b1;
        walk_release("R7");
    endtask

    task automatic t_short_pulse();
        @(negedge clk);
        ext_rst_n = 1'b0;
        #0.5;
        expect_out("R8 pulse", 1'b1, 1'b0, 1'b0);
        #0.5;
        ext_rst_n = 1'b1;
        #0.5;
        expect_out("R8 after pulse", 1'b1, 1'b0, 1'b0);
        walk_release("R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_release();
        t_hold();
        for (int k = 0; k < 3; k++) t_single_low(k);
        t_drop_in_float();
        t_drop_after_release();
        t_short_pulse();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule